// File: doc/BRIEF.md
# PCM Silence Detector with DSD Output Gate

This block sits beside a sigma-delta DSD modulator and watches the stereo PCM samples that feed it. Silence is judged only in the PCM domain, where a silent sample is exactly zero; a delta-sigma bitstream has no fixed code for silence, so it is never inspected. When no non-zero frame has arrived for a configurable number of milliseconds, the block raises an active-high mute flag and freezes the DSD clock and both DSD data lines low. Downstream equipment sees the missing pulse train and mutes.

Time is measured with a free-running 1 kHz tick, so the silence window does not depend on the sample rate, and any rate up to 192 kHz and beyond works unchanged. Playback resumes once a programmable run of consecutive non-zero frames has been seen. The gate only changes state on a system clock edge where the incoming DSD clock is low, so the gated clock never carries a shortened high pulse. All inputs are synchronous to `clk_i`; the block leaves reset in the muted state.

Top module: `pcm_silence_gate`

## Requirements
- R1: A frame (a cycle with `sample_valid_i` high) is silent only when both `left_i` and `right_i` equal zero; a frame with a non-zero value on either channel, including the right channel alone, restarts the silence window, so playback stays unmuted.
- R2: When `ms_tick_i` has pulsed `MUTE_MS` times (default 4) since the last non-zero frame, `mute_o` goes high; the tick count saturates at `MUTE_MS`.
- R3: With fewer than `MUTE_MS` ticks since the last non-zero frame, `mute_o` stays low.
- R4: `mute_o` is high while muted and low while playing.
- R5: While muted, `dsd_clk_o`, `dsd_l_o` and `dsd_r_o` are driven to 0 and do not toggle.
- R6: While playing, `dsd_clk_o`, `dsd_l_o` and `dsd_r_o` equal `dsd_clk_i`, `dsd_l_i` and `dsd_r_i` delayed by one clock.
- R7: Mute is released only after `UNMUTE_FRAMES` consecutive non-zero frames; a silent frame restarts that count.
- R8: `mute_o` changes only one clock after an edge at which `dsd_clk_i` was sampled 0, so no partial DSD clock pulse is output.
- R9: After reset, `mute_o` is 1 and all three gated DSD outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | One-cycle strobe marking a new stereo frame |
| left_i | input | SAMPLE_W | Left PCM sample, two's complement |
| right_i | input | SAMPLE_W | Right PCM sample, two's complement |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| dsd_clk_i | input | 1 | DSD bit clock from the modulator |
| dsd_l_i | input | 1 | Left DSD bit from the modulator |
| dsd_r_i | input | 1 | Right DSD bit from the modulator |
| dsd_clk_o | output | 1 | Gated DSD bit clock |
| dsd_l_o | output | 1 | Gated left DSD bit |
| dsd_r_o | output | 1 | Gated right DSD bit |
| mute_o | output | 1 | High while the output is muted |

## Verification
Frame and tick inputs land in the silence timer and frame-run counter one edge later, the mute flag follows one edge after that at the earliest (later if the DSD clock is high), and the gated DSD lines reflect a new mute state one further edge on, while in the playing state they trail their inputs by exactly one edge. The bench keeps a behavioural model that steps on the same rising edge as the design and compares every output at the following falling edge, so each result is checked in the cycle it is due. Directed checks wait out whole tick windows with margin on both sides of the 4 ms threshold, and a monitor confirms every change of the mute flag follows an edge with the DSD clock low.

// File: rtl/pcm_gate_pkg.sv
package pcm_gate_pkg;
  typedef struct packed {
    logic clk;
    logic dl;
    logic dr;
  } dsd_line_t;

  localparam dsd_line_t DSD_IDLE = '{clk: 1'b0, dl: 1'b0, dr: 1'b0};
endpackage

// File: rtl/pg_frame_class.sv
module pg_frame_class #(
  parameter int SAMPLE_W = 24
) (
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                nonzero_o,
  output logic                zero_o
);
  logic any_set;

  assign any_set   = (|left_i) | (|right_i);
  assign nonzero_o = sample_valid_i & any_set;
  assign zero_o    = sample_valid_i & ~any_set;
endmodule

// File: rtl/pg_silence_timer.sv
module pg_silence_timer #(
  parameter int MUTE_MS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nonzero_i,
  input  logic tick_i,
  output logic silent_o
);
  localparam int TIMER_W = $clog2(MUTE_MS + 1);
  localparam logic [TIMER_W-1:0] LIMIT = TIMER_W'(MUTE_MS);

  logic [TIMER_W-1:0] ms_q;

  // reset saturated: block starts muted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ms_q <= LIMIT;
    else if (nonzero_i)              ms_q <= '0;
    else if (tick_i && ms_q < LIMIT) ms_q <= ms_q + 1'b1;
  end

  assign silent_o = (ms_q == LIMIT);

  assert_timer_saturates_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_q <= LIMIT);

  assert_nonzero_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nonzero_i |=> !silent_o);
endmodule

// File: rtl/pg_run_counter.sv
module pg_run_counter #(
  parameter int UNMUTE_FRAMES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nonzero_i,
  input  logic zero_i,
  output logic ready_o
);
  localparam int RUN_W = $clog2(UNMUTE_FRAMES + 1);
  localparam logic [RUN_W-1:0] TARGET = RUN_W'(UNMUTE_FRAMES);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         run_q <= '0;
    else if (zero_i)                     run_q <= '0;
    else if (nonzero_i && run_q < TARGET) run_q <= run_q + 1'b1;
  end

  assign ready_o = (run_q == TARGET);

  assert_run_bounded_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= TARGET);
endmodule

// File: rtl/pg_dsd_gate.sv
module pg_dsd_gate
  import pcm_gate_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      silent_i,
  input  logic      ready_i,
  input  dsd_line_t dsd_i,
  output dsd_line_t dsd_o,
  output logic      mute_o
);
  logic      mute_q;
  dsd_line_t out_q;

  // state may only move while the DSD clock is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mute_q <= 1'b1;
    end else if (!dsd_i.clk) begin
      if (silent_i)     mute_q <= 1'b1;
      else if (ready_i) mute_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     out_q <= DSD_IDLE;
    else if (mute_q) out_q <= DSD_IDLE;
    else             out_q <= dsd_i;
  end

  assign dsd_o  = out_q;
  assign mute_o = mute_q;

  assert_muted_lines_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_q |=> (out_q == DSD_IDLE));

  assert_change_on_low_clk_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_q != $past(mute_q)) |-> !$past(dsd_i.clk));

  assert_release_needs_run_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mute_q) |-> $past(ready_i));

  assert_silence_mutes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (silent_i && !dsd_i.clk) |=> mute_q);
endmodule

// File: rtl/pcm_silence_gate.sv
module pcm_silence_gate
  import pcm_gate_pkg::*;
#(
  parameter int SAMPLE_W      = 24,
  parameter int MUTE_MS       = 4,
  parameter int UNMUTE_FRAMES = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                ms_tick_i,
  input  logic                dsd_clk_i,
  input  logic                dsd_l_i,
  input  logic                dsd_r_i,
  output logic                dsd_clk_o,
  output logic                dsd_l_o,
  output logic                dsd_r_o,
  output logic                mute_o
);
  logic      frame_nz, frame_z;
  logic      silent, ready;
  dsd_line_t dsd_in, dsd_out;

  pg_frame_class #(.SAMPLE_W(SAMPLE_W)) u_class (
    .sample_valid_i (sample_valid_i),
    .left_i         (left_i),
    .right_i        (right_i),
    .nonzero_o      (frame_nz),
    .zero_o         (frame_z)
  );

  pg_silence_timer #(.MUTE_MS(MUTE_MS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nonzero_i (frame_nz),
    .tick_i    (ms_tick_i),
    .silent_o  (silent)
  );

  pg_run_counter #(.UNMUTE_FRAMES(UNMUTE_FRAMES)) u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nonzero_i (frame_nz),
    .zero_i    (frame_z),
    .ready_o   (ready)
  );

  assign dsd_in = '{clk: dsd_clk_i, dl: dsd_l_i, dr: dsd_r_i};

  pg_dsd_gate u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .silent_i (silent),
    .ready_i  (ready),
    .dsd_i    (dsd_in),
    .dsd_o    (dsd_out),
    .mute_o   (mute_o)
  );

  assign dsd_clk_o = dsd_out.clk;
  assign dsd_l_o   = dsd_out.dl;
  assign dsd_r_o   = dsd_out.dr;

  assert_frame_class_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({frame_nz, frame_z}));
endmodule

// File: tb/pcm_silence_gate_tb.sv
module pcm_silence_gate_tb;
  localparam int SW   = 16;
  localparam int MMS  = 4;
  localparam int UF   = 3;
  localparam int TICK = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sv = 1'b0, tick = 1'b0, dclk = 1'b0, dl = 1'b0, dr = 1'b0;
  logic [SW-1:0] lft = '0, rgt = '0;
  logic dclk_o, dl_o, dr_o, mute_o;

  int checks = 0, fails = 0, cyc = 0, pat = 0;
  logic [7:0] lfsr = 8'h5a;
  logic prev_dclk = 1'b0, prev_mute = 1'b1;

  // reference model state
  int m_timer, m_run;
  logic m_mute, m_clk, m_l, m_r;

  always #2 clk = ~clk;

  pcm_silence_gate #(.SAMPLE_W(SW), .MUTE_MS(MMS), .UNMUTE_FRAMES(UF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(sv), .left_i(lft), .right_i(rgt),
    .ms_tick_i(tick), .dsd_clk_i(dclk), .dsd_l_i(dl), .dsd_r_i(dr),
    .dsd_clk_o(dclk_o), .dsd_l_o(dl_o), .dsd_r_o(dr_o), .mute_o(mute_o)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // stimulus generator
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    dclk = cyc[1];
    dl   = lfsr[0];
    dr   = lfsr[3];
    tick = (cyc % TICK) == 0;
    sv   = (cyc % 8) == 3;
    lft  = '0;
    rgt  = '0;
    if (sv) begin
      case (pat)
        1: lft = SW'(lfsr) | 16'h0100;
        2: rgt = 16'h8000;
        3: lft = ((cyc / 8) % 2 == 0) ? 16'h0001 : 16'h0000;
        default: ;
      endcase
    end
  end

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_timer = MMS; m_run = 0; m_mute = 1'b1;
      m_clk = 1'b0; m_l = 1'b0; m_r = 1'b0;
    end else begin
      logic nz, z, n_mute;
      nz = sv && (lft != 0 || rgt != 0);
      z  = sv && lft == 0 && rgt == 0;
      m_clk = m_mute ? 1'b0 : dclk;
      m_l   = m_mute ? 1'b0 : dl;
      m_r   = m_mute ? 1'b0 : dr;
      n_mute = m_mute;
      if (!dclk) begin
        if (m_timer == MMS)  n_mute = 1'b1;
        else if (m_run == UF) n_mute = 1'b0;
      end
      m_mute = n_mute;
      if (nz)                        m_timer = 0;
      else if (tick && m_timer < MMS) m_timer = m_timer + 1;
      if (z)       m_run = 0;
      else if (nz) m_run = (m_run < UF) ? m_run + 1 : UF;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(mute_o === m_mute, "R4 mute_o", mute_o, m_mute);
      check(dclk_o === m_clk, m_mute ? "R5 dsd_clk_o" : "R6 dsd_clk_o", dclk_o, m_clk);
      check({dl_o, dr_o} === {m_l, m_r}, m_mute ? "R5 dsd data" : "R6 dsd data",
            {dl_o, dr_o}, {m_l, m_r});
      if (mute_o !== prev_mute)
        check(prev_dclk === 1'b0, "R8 mute change with dsd clock high", prev_dclk, 0);
    end
    prev_mute = mute_o;
    prev_dclk = dclk;
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(3);
    check(mute_o === 1'b1, "R9 reset mute", mute_o, 1);
    check({dclk_o, dl_o, dr_o} === 3'b000, "R9 reset lines", {dclk_o, dl_o, dr_o}, 0);
    rst_n = 1'b1;
    wait_cyc(30);
    check(mute_o === 1'b1, "R9 muted until data", mute_o, 1);

    pat = 1;
    wait_cyc(12);
    check(mute_o === 1'b1, "R7 not released before run complete", mute_o, 1);
    wait_cyc(40);
    check(mute_o === 1'b0, "R7 released after run", mute_o, 0);
    check(mute_o === 1'b0, "R4 playing low", mute_o, 0);

    pat = 0;
    wait_cyc(140);
    check(mute_o === 1'b0, "R3 under threshold", mute_o, 0);
    wait_cyc(120);
    check(mute_o === 1'b1, "R2 muted after window", mute_o, 1);
    for (int i = 0; i < 20; i++) begin
      wait_cyc(1);
      check({dclk_o, dl_o, dr_o} === 3'b000, "R5 lines frozen", {dclk_o, dl_o, dr_o}, 0);
    end

    pat = 2;
    wait_cyc(60);
    check(mute_o === 1'b0, "R1 right channel alone unmutes", mute_o, 0);
    wait_cyc(300);
    check(mute_o === 1'b0, "R1 right-only stays playing", mute_o, 0);

    pat = 0;
    wait_cyc(260);
    check(mute_o === 1'b1, "R2 muted again", mute_o, 1);
    pat = 3;
    wait_cyc(300);
    check(mute_o === 1'b1, "R7 alternating frames keep mute", mute_o, 1);

    pat = 1;
    wait_cyc(60);
    check(mute_o === 1'b0, "R6 playing resumes", mute_o, 0);
    wait_cyc(40);
    finish_run();
  end
endmodule